// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the word address presented to a synchronous burst memory. A burst opens when a processor-side or a cache-controller-side start strobe is sampled low. That clock edge loads the external address into a base register and clears a two-bit position counter. The ordering choice is loaded at the same edge.

Each later edge with the advance input low moves the position counter forward by one. The two low address bits are then derived from the captured start bits and the position. The derivation is either a modulo-four increment or a bitwise exclusive-or, depending on the ordering chosen when the burst began. The upper address bits stay at their captured value for the whole burst.

The outputs are the composed address and the current position within the four-word burst. Every input is sampled on the rising clock edge. Both outputs therefore reflect the registers updated at the most recent edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted (rst_n low) and after its release, before any strobe, addr_out and burst_pos are both zero.
- R2: A rising edge with proc_start_n low or ctrl_start_n low (either or both) loads addr_in. From the following cycle, addr_out equals that addr_in and burst_pos is 0.
- R3: A rising edge with adv_n low and both start strobes high raises burst_pos by one, wrapping from 3 to 0.
- R4: With order_sel low at burst start (linear order), addr_out[1:0] equals (start low bits + burst_pos) modulo 4.
- R5: With order_sel high at burst start (interleaved order), addr_out[1:0] equals start low bits XOR burst_pos.
- R6: Within a burst, addr_out[ADDR_W-1:2] keeps its captured value, including when the low bits wrap.
- R7: When a start strobe and adv_n are both low at the same edge, the start takes effect and no advance happens: burst_pos becomes 0 and addr_out becomes addr_in.
- R8: An edge with both strobes high and adv_n high leaves addr_out and burst_pos unchanged.
- R9: order_sel is sampled only at a burst start. Changing it during a burst has no effect on the address sequence of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W | External start address |
| proc_start_n | input | 1 | Processor-side burst start, active low |
| ctrl_start_n | input | 1 | Cache-controller-side burst start, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | 0 selects linear order, 1 selects interleaved order |
| addr_out | output | ADDR_W | Current word address |
| burst_pos | output | 2 | Position within the burst (0 to 3) |

## Verification
The bench builds the block with ADDR_W = 6. This leaves 64 start addresses, all of which the bench sweeps. It walks each one through six advances under both orderings and both strobes. Six advances is enough to force the low bits past the four-word wrap from every start offset and to expose any carry into the upper bits. Directed sequences then cover priority of a start over an advance, idle holding, a mid-burst ordering change and a restart in the middle of a burst.

// File: rtl/bas_pkg.sv
package bas_pkg;

  localparam int BURST_BITS = 2;

  typedef logic [BURST_BITS-1:0] bpos_t;

  // Linear order: start offset plus position, wrapping within the burst.
  function automatic bpos_t low_linear(bpos_t start_low, bpos_t pos);
    return bpos_t'(start_low + pos);
  endfunction

  // Interleaved order: start offset toggled by the position bits.
  function automatic bpos_t low_interleave(bpos_t start_low, bpos_t pos);
    return start_low ^ pos;
  endfunction

endpackage

// File: rtl/bas_capture.sv
module bas_capture #(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              order_in,
  output logic [ADDR_W-1:0] base_q,
  output logic              order_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      order_q <= 1'b0;
    end else if (start_evt) begin
      base_q  <= addr_in;
      order_q <= order_in;
    end
  end

endmodule

// File: rtl/bas_counter.sv
module bas_counter
  import bas_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_evt,
  input  logic  step_evt,
  output bpos_t pos_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (start_evt) begin
      pos_q <= '0;
    end else if (step_evt) begin
      pos_q <= bpos_t'(pos_q + 1'b1);
    end
  end

endmodule

// File: rtl/bas_lowmap.sv
module bas_lowmap
  import bas_pkg::*;
(
  input  bpos_t start_low,
  input  bpos_t pos,
  input  logic  interleave,
  output bpos_t low_out
);

  bpos_t lin_low;
  bpos_t il_low;

  assign lin_low = low_linear(start_low, pos);
  assign il_low  = low_interleave(start_low, pos);
  assign low_out = interleave ? il_low : lin_low;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              proc_start_n,
  input  logic              ctrl_start_n,
  input  logic              adv_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        burst_pos
);

  localparam int UPPER_W = ADDR_W - BURST_BITS;

  // Named events for the checker.
  logic start_evt;
  logic step_evt;

  logic [ADDR_W-1:0] base_q;
  logic              order_q;
  bpos_t             pos_q;
  bpos_t             low_bits;

  assign start_evt = !proc_start_n || !ctrl_start_n;
  assign step_evt  = !adv_n && !start_evt;

  bas_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .addr_in   (addr_in),
    .order_in  (order_sel),
    .base_q    (base_q),
    .order_q   (order_q)
  );

  bas_counter u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .step_evt  (step_evt),
    .pos_q     (pos_q)
  );

  bas_lowmap u_lowmap (
    .start_low  (base_q[BURST_BITS-1:0]),
    .pos        (pos_q),
    .interleave (order_q),
    .low_out    (low_bits)
  );

  assign addr_out  = {base_q[ADDR_W-1 -: UPPER_W], low_bits};
  assign burst_pos = pos_q;

endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              adv_n,
  input logic              order_sel,
  input logic              start_evt,
  input logic              step_evt,
  input logic              order_q,
  input logic [ADDR_W-1:0] addr_out,
  input logic [1:0]        burst_pos
);

  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (addr_out == $past(addr_in)) && (burst_pos == 2'd0));

  assert_step_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> burst_pos == 2'($past(burst_pos) + 2'd1));

  assert_upper_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !start_evt |=> $stable(addr_out[ADDR_W-1:2]));

  assert_start_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !adv_n) |=> burst_pos == 2'd0);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_evt && adv_n) |=> ($stable(addr_out) && $stable(burst_pos)));

  assert_order_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !start_evt |=> $stable(order_q));

  assert_order_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> order_q == $past(order_sel));

endmodule

bind burst_addr_seq bas_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_in   (addr_in),
  .adv_n     (adv_n),
  .order_sel (order_sel),
  .start_evt (start_evt),
  .step_evt  (step_evt),
  .order_q   (order_q),
  .addr_out  (addr_out),
  .burst_pos (burst_pos)
);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;

  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          proc_start_n = 1'b1;
  logic          ctrl_start_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          order_sel = 1'b0;
  logic [AW-1:0] addr_out;
  logic [1:0]    burst_pos;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Bench-side model state.
  logic [AW-1:0] m_base;
  int            m_pos;
  bit            m_il;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_in      (addr_in),
    .proc_start_n (proc_start_n),
    .ctrl_start_n (ctrl_start_n),
    .adv_n        (adv_n),
    .order_sel    (order_sel),
    .addr_out     (addr_out),
    .burst_pos    (burst_pos)
  );

  function automatic logic [AW-1:0] expect_addr();
    int lo;
    int s = int'(m_base) % 4;
    if (m_il) lo = s ^ m_pos;
    else      lo = (s + m_pos) % 4;
    return logic'(0) | ((m_base / 4) * 4 + lo);
  endfunction

  task automatic check(string req);
    logic [AW-1:0] ea = expect_addr();
    checks++;
    if (addr_out !== ea || burst_pos !== 2'(m_pos)) begin
      failures++;
      $display("FAIL %s addr=%0d pos=%0d expected addr=%0d pos=%0d",
               req, addr_out, burst_pos, ea, m_pos);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic start(int sel, logic [AW-1:0] a, bit il, bit adv_too);
    addr_in = a;
    order_sel = il;
    proc_start_n = !(sel == 0 || sel == 2);
    ctrl_start_n = !(sel == 1 || sel == 2);
    adv_n = !adv_too;
    tick();
    proc_start_n = 1'b1;
    ctrl_start_n = 1'b1;
    adv_n = 1'b1;
    m_base = a;
    m_pos = 0;
    m_il = il;
  endtask

  task automatic step();
    adv_n = 1'b0;
    tick();
    adv_n = 1'b1;
    m_pos = (m_pos + 1) % 4;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    m_base = '0; m_pos = 0; m_il = 0;
    check("R1 during reset");
    rst_n = 1'b1;
    tick();
    tick();
    check("R1 after release");

    // Sweep: both orders, both strobes, every start address, six advances.
    for (int il = 0; il < 2; il++) begin
      for (int sel = 0; sel < 2; sel++) begin
        for (int a = 0; a < 64; a++) begin
          start(sel, AW'(a), il[0], 1'b0);
          check("R2 start load");
          for (int k = 0; k < 6; k++) begin
            step();
            if (il != 0) check("R5 interleaved R3 R6");
            else         check("R4 linear R3 R6");
          end
        end
      end
    end

    // Both strobes together.
    start(2, 6'd37, 1'b0, 1'b0);
    check("R2 both strobes");

    // Start with advance in the same cycle: start wins.
    step();
    step();
    start(0, 6'd22, 1'b1, 1'b1);
    check("R7 proc start over advance");
    start(1, 6'd45, 1'b0, 1'b1);
    check("R7 ctrl start over advance");

    // Idle cycles hold.
    step();
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R8 idle hold");
    end

    // Order change mid-burst is ignored.
    start(0, 6'd13, 1'b0, 1'b0);
    order_sel = 1'b1;
    for (int k = 0; k < 5; k++) begin
      step();
      check("R9 order held linear");
    end
    start(1, 6'd58, 1'b1, 1'b0);
    order_sel = 1'b0;
    for (int k = 0; k < 5; k++) begin
      step();
      check("R9 order held interleaved");
    end

    // Restart in the middle of a burst.
    step();
    start(0, 6'd3, 1'b0, 1'b0);
    check("R2 restart mid-burst");
    step();
    check("R4 after restart");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule